// File: doc/BRIEF.md
# Calendar Validator and BCD Field Converter

This block sits between software-visible binary time and the two-digit BCD register layout of a battery-backed clock chip. It has two independent channels. The set channel takes a full binary year, a month counted from zero, and the day, hour, minute and second. It checks them against calendar rules, including Gregorian leap years. It then folds the year into a two-digit value inside a fixed hundred-year window and returns six BCD bytes, or an error strobe when any check fails.

The get channel takes six BCD bytes as read back from the chip. It returns binary fields: a year counted from 1900, a month counted from zero, and the day and time of day. Each channel has a valid/ready request side and a valid/ready result side. A request accepted at a clock edge produces a registered result in the next cycle. That result is held until it is taken. Serial transport to the chip belongs elsewhere.

Top module: `rtc_cal_conv`

## Requirements
- R1: After reset both request sides are ready (`setReady`, `getReady` high) and no result is presented (`encValid`, `encErr`, `decValid` low).
- R2: A set request accepted at a clock edge (`setValid` and `setReady` both high) produces exactly one of `encValid` or `encErr` from the following cycle. That result and its fields stay unchanged until a cycle with `encReady` high. `setReady` is low while the result is held, and a request offered in that time is ignored.
- R3: A year outside 1970 to 2069 inclusive is flagged as an error.
- R4: The month input counts from 0. An input above 11 is an error. The encoded month is the input plus one.
- R5: A day of zero is an error. A day above the month length is an error. Month lengths, January first, are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days in a leap year. A leap year is divisible by 400, or divisible by 4 but not by 100.
- R6: An hour of 24 or more, a minute of 60 or more, or a second of 60 or more is an error.
- R7: Years 2000 to 2069 encode as year minus 2000. Years 1970 to 1999 encode as year minus 1900.
- R8: Each encoded field is one byte, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R9: When any check fails, `encErr` is high and `encValid` stays low for that result.
- R10: The get channel decodes each BCD byte to binary. A decoded year of 69 or less gains 100, giving years since 1900. The month is decremented by one. `decValid` follows an accepted request by one cycle and holds with stable fields until `decReady` is high.
- R11: Set and get requests accepted at the same edge are processed independently. Both results appear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setValid | input | 1 | Set request offered |
| setReady | output | 1 | Set request can be accepted |
| setYear | input | 12 | Full binary year |
| setMonth | input | 4 | Month, 0 = January |
| setDay | input | 5 | Day of month |
| setHour | input | 5 | Hour |
| setMin | input | 6 | Minute |
| setSec | input | 6 | Second |
| encValid | output | 1 | Encoded result held, all checks passed |
| encErr | output | 1 | Result held, a check failed |
| encReady | input | 1 | Consumer takes the set result |
| encYear | output | 8 | BCD two-digit year |
| encMonth | output | 8 | BCD month 01..12 |
| encDay | output | 8 | BCD day |
| encHour | output | 8 | BCD hour |
| encMin | output | 8 | BCD minute |
| encSec | output | 8 | BCD second |
| getValid | input | 1 | Get request offered |
| getReady | output | 1 | Get request can be accepted |
| getYear | input | 8 | BCD two-digit year |
| getMonth | input | 8 | BCD month 01..12 |
| getDay | input | 8 | BCD day |
| getHour | input | 8 | BCD hour |
| getMin | input | 8 | BCD minute |
| getSec | input | 8 | BCD second |
| decValid | output | 1 | Decoded result held |
| decReady | input | 1 | Consumer takes the get result |
| decYear | output | 8 | Years since 1900 |
| decMonth | output | 4 | Month, 0 = January |
| decDay | output | 5 | Day of month |
| decHour | output | 5 | Hour |
| decMin | output | 6 | Minute |
| decSec | output | 6 | Second |

## Verification
The set encoder and the get decoder can both accept a request at the same clock edge. The main sweep provokes this on every date from 1970 through 2069. It offers the binary date on the set side and, in the same cycle, its expected BCD image on the get side. Both results are judged one cycle later against separately computed reference values, so any interaction between the channels shows up as a mismatch on one of them.

// File: rtl/calconv_pkg.sv
package calconv_pkg;

  typedef struct packed {
    logic loadSet;
    logic loadGet;
  } calStrobes_t;

  function automatic logic [7:0] toBcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [6:0] fromBcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // month counted from 1
  function automatic logic [4:0] monthLen(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import calconv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        setValid,
  input  logic        getValid,
  input  logic        encReady,
  input  logic        decReady,
  output calStrobes_t strobes,
  output logic        setPend,
  output logic        getPend,
  output logic        setReady,
  output logic        getReady
);

  assign setReady        = !setPend;
  assign getReady        = !getPend;
  assign strobes.loadSet = setValid && setReady;
  assign strobes.loadGet = getValid && getReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setPend <= 1'b0;
      getPend <= 1'b0;
    end else begin
      if (strobes.loadSet)          setPend <= 1'b1;
      else if (setPend && encReady) setPend <= 1'b0;
      if (strobes.loadGet)          getPend <= 1'b1;
      else if (getPend && decReady) getPend <= 1'b0;
    end
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import calconv_pkg::*;
#(
  parameter int YEAR_W    = 12,
  parameter int WIN_START = 1970
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       strobes,
  input  logic [YEAR_W-1:0] setYear,
  input  logic [3:0]        setMonth,
  input  logic [4:0]        setDay,
  input  logic [4:0]        setHour,
  input  logic [5:0]        setMin,
  input  logic [5:0]        setSec,
  output logic              badQ,
  output logic [7:0]        encYear,
  output logic [7:0]        encMonth,
  output logic [7:0]        encDay,
  output logic [7:0]        encHour,
  output logic [7:0]        encMin,
  output logic [7:0]        encSec,
  input  logic [7:0]        getYear,
  input  logic [7:0]        getMonth,
  input  logic [7:0]        getDay,
  input  logic [7:0]        getHour,
  input  logic [7:0]        getMin,
  input  logic [7:0]        getSec,
  output logic [7:0]        decYear,
  output logic [3:0]        decMonth,
  output logic [4:0]        decDay,
  output logic [4:0]        decHour,
  output logic [5:0]        decMin,
  output logic [5:0]        decSec
);

  localparam int FIELDS  = 6;
  localparam int CENT    = (WIN_START / 100) * 100;
  localparam logic [YEAR_W-1:0] YEAR_LO  = YEAR_W'(WIN_START);
  localparam logic [YEAR_W-1:0] YEAR_HI  = YEAR_W'(WIN_START + 99);
  localparam logic [YEAR_W-1:0] CENT_LO  = YEAR_W'(CENT);
  localparam logic [YEAR_W-1:0] PIVOT    = YEAR_W'(CENT + 100);
  localparam logic [6:0]        FOLD_MAX = 7'(WIN_START - CENT - 1);

  // ---- set side: checks ----
  logic       yearOk, monthOk, dayOk, timeOk, leap;
  logic [3:0] monthN;
  logic [4:0] dayMax;
  logic [6:0] yrFold;

  assign leap    = ((setYear % YEAR_W'(4)) == '0 && (setYear % YEAR_W'(100)) != '0)
                || ((setYear % YEAR_W'(400)) == '0);
  assign yearOk  = (setYear >= YEAR_LO) && (setYear <= YEAR_HI);
  assign monthOk = setMonth <= 4'd11;
  assign monthN  = setMonth + 4'd1;
  assign dayMax  = monthLen(monthN, leap);
  assign dayOk   = (setDay != 5'd0) && (setDay <= dayMax);
  assign timeOk  = (setHour < 5'd24) && (setMin < 6'd60) && (setSec < 6'd60);
  assign yrFold  = 7'((setYear >= PIVOT) ? (setYear - PIVOT) : (setYear - CENT_LO));

  // ---- set side: encoding ----
  logic [6:0] binF [FIELDS];
  logic [7:0] bcdQ [FIELDS];

  assign binF[0] = yrFold;
  assign binF[1] = {3'b000, monthN};
  assign binF[2] = {2'b00, setDay};
  assign binF[3] = {2'b00, setHour};
  assign binF[4] = {1'b0, setMin};
  assign binF[5] = {1'b0, setSec};

  for (genvar i = 0; i < FIELDS; i++) begin : gEnc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                bcdQ[i] <= 8'h00;
      else if (strobes.loadSet) bcdQ[i] <= toBcd(binF[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                badQ <= 1'b0;
    else if (strobes.loadSet) badQ <= !(yearOk && monthOk && dayOk && timeOk);
  end

  assign encYear  = bcdQ[0];
  assign encMonth = bcdQ[1];
  assign encDay   = bcdQ[2];
  assign encHour  = bcdQ[3];
  assign encMin   = bcdQ[4];
  assign encSec   = bcdQ[5];

  // ---- get side ----
  logic [6:0] yrBin;
  logic [7:0] yrOut;

  assign yrBin = fromBcd(getYear);
  assign yrOut = (yrBin <= FOLD_MAX) ? ({1'b0, yrBin} + 8'd100) : {1'b0, yrBin};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decYear  <= '0;
      decMonth <= '0;
      decDay   <= '0;
      decHour  <= '0;
      decMin   <= '0;
      decSec   <= '0;
    end else if (strobes.loadGet) begin
      decYear  <= yrOut;
      decMonth <= 4'(fromBcd(getMonth)) - 4'd1;
      decDay   <= 5'(fromBcd(getDay));
      decHour  <= 5'(fromBcd(getHour));
      decMin   <= 6'(fromBcd(getMin));
      decSec   <= 6'(fromBcd(getSec));
    end
  end

endmodule

// File: rtl/rtc_cal_conv.sv
module rtc_cal_conv
  import calconv_pkg::*;
#(
  parameter int YEAR_W    = 12,
  parameter int WIN_START = 1970
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  output logic              setReady,
  input  logic [YEAR_W-1:0] setYear,
  input  logic [3:0]        setMonth,
  input  logic [4:0]        setDay,
  input  logic [4:0]        setHour,
  input  logic [5:0]        setMin,
  input  logic [5:0]        setSec,
  output logic              encValid,
  output logic              encErr,
  input  logic              encReady,
  output logic [7:0]        encYear,
  output logic [7:0]        encMonth,
  output logic [7:0]        encDay,
  output logic [7:0]        encHour,
  output logic [7:0]        encMin,
  output logic [7:0]        encSec,
  input  logic              getValid,
  output logic              getReady,
  input  logic [7:0]        getYear,
  input  logic [7:0]        getMonth,
  input  logic [7:0]        getDay,
  input  logic [7:0]        getHour,
  input  logic [7:0]        getMin,
  input  logic [7:0]        getSec,
  output logic              decValid,
  input  logic              decReady,
  output logic [7:0]        decYear,
  output logic [3:0]        decMonth,
  output logic [4:0]        decDay,
  output logic [4:0]        decHour,
  output logic [5:0]        decMin,
  output logic [5:0]        decSec
);

  calStrobes_t strobes;
  logic        setPend, getPend, badQ;

  cal_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .setValid (setValid),
    .getValid (getValid),
    .encReady (encReady),
    .decReady (decReady),
    .strobes  (strobes),
    .setPend  (setPend),
    .getPend  (getPend),
    .setReady (setReady),
    .getReady (getReady)
  );

  cal_datapath #(.YEAR_W(YEAR_W), .WIN_START(WIN_START)) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .setYear  (setYear),
    .setMonth (setMonth),
    .setDay   (setDay),
    .setHour  (setHour),
    .setMin   (setMin),
    .setSec   (setSec),
    .badQ     (badQ),
    .encYear  (encYear),
    .encMonth (encMonth),
    .encDay   (encDay),
    .encHour  (encHour),
    .encMin   (encMin),
    .encSec   (encSec),
    .getYear  (getYear),
    .getMonth (getMonth),
    .getDay   (getDay),
    .getHour  (getHour),
    .getMin   (getMin),
    .getSec   (getSec),
    .decYear  (decYear),
    .decMonth (decMonth),
    .decDay   (decDay),
    .decHour  (decHour),
    .decMin   (decMin),
    .decSec   (decSec)
  );

  assign encValid = setPend && !badQ;
  assign encErr   = setPend && badQ;
  assign decValid = getPend;

endmodule

// File: rtl/cal_conv_chk.sv
module cal_conv_chk (
  input logic       clk,
  input logic       rstN,
  input logic       setValid,
  input logic       setReady,
  input logic       encValid,
  input logic       encErr,
  input logic       encReady,
  input logic [7:0] encYear,
  input logic [7:0] encMonth,
  input logic [7:0] encDay,
  input logic [7:0] encHour,
  input logic [7:0] encMin,
  input logic [7:0] encSec,
  input logic       getValid,
  input logic       getReady,
  input logic       decValid,
  input logic       decReady,
  input logic [7:0] decYear,
  input logic [3:0] decMonth,
  input logic [4:0] decDay,
  input logic [4:0] decHour,
  input logic [5:0] decMin,
  input logic [5:0] decSec
);

  // R9
  enc_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(encValid && encErr));

  // R2
  set_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (encValid || encErr) |-> !setReady);

  // R2
  set_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && setReady) |=> (encValid ^ encErr));

  // R2
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (encValid && !encReady) |=> (encValid && $stable(encYear) && $stable(encMonth)
      && $stable(encDay) && $stable(encHour) && $stable(encMin) && $stable(encSec)));

  // R8
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid |-> (encYear[7:4] <= 4'd9 && encYear[3:0] <= 4'd9
      && encMonth[7:4] <= 4'd9 && encMonth[3:0] <= 4'd9
      && encDay[7:4] <= 4'd9 && encDay[3:0] <= 4'd9
      && encHour[7:4] <= 4'd9 && encHour[3:0] <= 4'd9
      && encMin[7:4] <= 4'd9 && encMin[3:0] <= 4'd9
      && encSec[7:4] <= 4'd9 && encSec[3:0] <= 4'd9));

  // R6
  time_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid |-> (encHour <= 8'h23 && encMin <= 8'h59 && encSec <= 8'h59));

  // R4
  month_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    encValid |-> (encMonth >= 8'h01 && encMonth <= 8'h12));

  // R10
  get_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (getValid && getReady) |=> decValid);

  // R10
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decReady) |=> (decValid && !getReady && $stable(decYear)
      && $stable(decMonth) && $stable(decDay) && $stable(decHour)
      && $stable(decMin) && $stable(decSec)));

endmodule

bind rtc_cal_conv cal_conv_chk chkI (.*);

// File: tb/tb_rtc_cal_conv.sv
`timescale 1ns/1ps
module tb_rtc_cal_conv;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setValid = 1'b0, setReady;
  logic [11:0] setYear = '0;
  logic [3:0]  setMonth = '0;
  logic [4:0]  setDay = '0, setHour = '0;
  logic [5:0]  setMin = '0, setSec = '0;
  logic        encValid, encErr, encReady = 1'b1;
  logic [7:0]  encYear, encMonth, encDay, encHour, encMin, encSec;
  logic        getValid = 1'b0, getReady;
  logic [7:0]  getYear = '0, getMonth = '0, getDay = '0, getHour = '0, getMin = '0, getSec = '0;
  logic        decValid, decReady = 1'b1;
  logic [7:0]  decYear;
  logic [3:0]  decMonth;
  logic [4:0]  decDay, decHour;
  logic [5:0]  decMin, decSec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rtc_cal_conv dut (.*);

  // ---------------- reference model ----------------
  function automatic bit refLeap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int refLen(int m1, bit lp);
    if (m1 == 2) return lp ? 29 : 28;
    if (m1 == 4 || m1 == 6 || m1 == 9 || m1 == 11) return 30;
    return 31;
  endfunction

  function automatic bit refOk(int y, int m0, int d, int h, int mi, int s);
    if (y < 1970 || y > 2069) return 0;
    if (m0 > 11 || d == 0) return 0;
    if (d > refLen(m0 + 1, refLeap(y))) return 0;
    if (h >= 24 || mi >= 60 || s >= 60) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] refBcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int refFold(int y);
    return (y >= 2000) ? y - 2000 : y - 1900;
  endfunction

  task automatic note(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic driveSet(int y, int m0, int d, int h, int mi, int s);
    setYear = 12'(y); setMonth = 4'(m0); setDay = 5'(d);
    setHour = 5'(h);  setMin = 6'(mi);   setSec = 6'(s);
  endtask

  task automatic driveGet(logic [7:0] y, logic [7:0] m, logic [7:0] d,
                          logic [7:0] h, logic [7:0] mi, logic [7:0] s);
    getYear = y; getMonth = m; getDay = d; getHour = h; getMin = mi; getSec = s;
  endtask

  task automatic judgeSet(int y, int m0, int d, int h, int mi, int s, string req);
    logic [47:0] exp, act;
    if (refOk(y, m0, d, h, mi, s)) begin
      note(encValid && !encErr, req, "set strobe", {encValid, encErr}, 2'b10);
      exp = {refBcd(refFold(y)), refBcd(m0 + 1), refBcd(d), refBcd(h), refBcd(mi), refBcd(s)};
      act = {encYear, encMonth, encDay, encHour, encMin, encSec};
      note(act == exp, req, "bcd fields", act, exp);
    end else begin
      // R9: error strobe only
      note(encErr && !encValid, req, "error strobe", {encValid, encErr}, 2'b01);
    end
  endtask

  task automatic judgeGet(int yrs, int m0, int d, int h, int mi, int s, string req);
    logic [33:0] exp, act;
    note(decValid, req, "get strobe", decValid, 1);
    exp = {8'(yrs), 4'(m0), 5'(d), 5'(h), 6'(mi), 6'(s)};
    act = {decYear, decMonth, decDay, decHour, decMin, decSec};
    note(act == exp, req, "decoded fields", act, exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic setCase(int y, int m0, int d, int h, int mi, int s, string req);
    @(negedge clk);
    driveSet(y, m0, d, h, mi, s);
    setValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    setValid = 1'b0;
    judgeSet(y, m0, d, h, mi, s, req);
  endtask

  task automatic getCase(logic [7:0] y, logic [7:0] m, logic [7:0] d, logic [7:0] h,
                         logic [7:0] mi, logic [7:0] s,
                         int eY, int eM, int eD, int eH, int eMi, int eS, string req);
    @(negedge clk);
    driveGet(y, m, d, h, mi, s);
    getValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    getValid = 1'b0;
    judgeGet(eY, eM, eD, eH, eMi, eS, req);
  endtask

  // R11: both channels in the same cycle
  task automatic pairCase(int y, int m0, int d, int h, int mi, int s);
    @(negedge clk);
    driveSet(y, m0, d, h, mi, s);
    driveGet(refBcd(refFold(y)), refBcd(m0 + 1), refBcd(d), refBcd(h), refBcd(mi), refBcd(s));
    setValid = 1'b1;
    getValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    setValid = 1'b0;
    getValid = 1'b0;
    judgeSet(y, m0, d, h, mi, s, "R11 R7 R8 set");
    judgeGet(y - 1900, m0, d, h, mi, s, "R11 R10 get");
  endtask

  task automatic resetCheck();
    note(setReady && getReady, "R1", "readies", {setReady, getReady}, 2'b11);
    note(!encValid && !encErr && !decValid, "R1", "no result",
         {encValid, encErr, decValid}, 3'b000);
  endtask

  task automatic sweepDays();
    for (int y = 1970; y <= 2069; y++) begin
      for (int m = 0; m < 12; m++) begin
        int len = refLen(m + 1, refLeap(y));
        for (int d = 1; d <= len; d++)
          pairCase(y, m, d, (d + m) % 24, (y + d) % 60, (d * 7) % 60);
        setCase(y, m, len + 1, 0, 0, 0, "R5 day past month end");
      end
    end
  endtask

  task automatic invalidSet();
    setCase(1969, 11, 31, 23, 59, 59, "R3 below window");
    setCase(2070, 0, 1, 0, 0, 0, "R3 above window");
    setCase(1970, 0, 1, 0, 0, 0, "R3 first year");
    setCase(2069, 11, 31, 23, 59, 59, "R3 R7 last year");
    setCase(2000, 12, 1, 0, 0, 0, "R4 month 12");
    setCase(2000, 15, 1, 0, 0, 0, "R4 month 15");
    setCase(2010, 0, 0, 0, 0, 0, "R5 day zero");
    setCase(2001, 1, 29, 0, 0, 0, "R5 feb29 common");
    setCase(2000, 1, 29, 0, 0, 0, "R5 feb29 div400");
    setCase(1996, 1, 30, 0, 0, 0, "R5 feb30 leap");
    setCase(2030, 3, 31, 0, 0, 0, "R5 april31");
    setCase(2030, 2, 31, 5, 6, 7, "R5 march31");
    setCase(2030, 2, 5, 24, 0, 0, "R6 hour24");
    setCase(2030, 2, 5, 23, 60, 0, "R6 min60");
    setCase(2030, 2, 5, 23, 59, 60, "R6 sec60");
    setCase(1999, 11, 31, 23, 59, 59, "R7 last pre-pivot");
    setCase(2000, 0, 1, 0, 0, 0, "R7 pivot");
  endtask

  task automatic getSpecials();
    getCase(8'h69, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 169, 11, 31, 23, 59, 59, "R10 fold 69");
    getCase(8'h70, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 70, 0, 1, 0, 0, 0, "R10 year 70");
    getCase(8'h00, 8'h02, 8'h29, 8'h12, 8'h34, 8'h56, 100, 1, 29, 12, 34, 56, "R10 year 00");
    getCase(8'h99, 8'h10, 8'h15, 8'h09, 8'h08, 8'h07, 99, 9, 15, 9, 8, 7, "R10 year 99");
  endtask

  task automatic holdSet();
    encReady = 1'b0;
    @(negedge clk);
    driveSet(2024, 1, 29, 12, 34, 56);
    setValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    driveSet(1999, 5, 6, 7, 8, 9);   // offered while held: must be ignored
    repeat (3) @(negedge clk);
    note(!setReady, "R2", "ready while held", setReady, 0);
    judgeSet(2024, 1, 29, 12, 34, 56, "R2 held result");
    setValid = 1'b0;
    encReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    note(!encValid && !encErr && setReady, "R2", "ignored request",
         {encValid, encErr, setReady}, 3'b001);
  endtask

  task automatic holdGet();
    decReady = 1'b0;
    @(negedge clk);
    driveGet(8'h45, 8'h07, 8'h04, 8'h18, 8'h30, 8'h00);
    getValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    driveGet(8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11);
    repeat (3) @(negedge clk);
    note(!getReady, "R10", "ready while held", getReady, 0);
    judgeGet(145, 6, 4, 18, 30, 0, "R10 held result");
    getValid = 1'b0;
    decReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    note(!decValid && getReady, "R10", "ignored request", {decValid, getReady}, 2'b01);
    getCase(8'h45, 8'h07, 8'h04, 8'h18, 8'h30, 8'h00, 145, 6, 4, 18, 30, 0, "R10 after hold");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetCheck();
    invalidSet();
    getSpecials();
    holdSet();
    holdGet();
    sweepDays();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule